// File: doc/BRIEF.md
# Latched Serial Register Front End for a Current-Output DAC

This block is the digital front end of a current-output converter. A host shifts 24-bit frames into it over a serial link made of a bit clock, a data input and a commit strobe. The link is sampled by the block's own system clock. Shifting runs freely. Nothing is acted upon until the commit strobe rises, and at that point the last 24 bits shifted in are decoded: the upper byte is a command address and the lower 16 bits are its payload.

The block holds a converter code register and a control register. It drives the converter code, an output-enable bit and a two-bit range select towards the analog section. A host can read a register back through the serial output during the frame that follows a read request. A keyed write returns every register to its power-on value. With chaining switched on, the serial output repeats the shift register, so several parts can sit on one link. An asynchronous clear input forces the code to the bottom of the selected range without losing the stored code.

Top module: `dac_serial_front`

## Requirements
- R1: After a synchronous active-low reset, the code, the output enable and the range select are all zero, and the serial output is low.
- R2: The data input is taken on each rising edge of the bit clock, MSB first. At a commit, bits 23..16 of the last 24 bits taken are the address and bits 15..0 are the payload. Bits taken earlier than those 24 have no effect.
- R3: Registers change only when the commit strobe rises. Holding the strobe high does not stop shifting, and it does not commit a second time.
- R4: Address 0x01 stores the payload as the converter code. The code is visible one clock after the commit.
- R5: Address 0x55 writes the control register. Payload bits 1..0 set the range (00 = 4 to 20 mA, 01 = 0 to 20 mA, 10 = 0 to 24 mA, 11 reserved). Bit 3 enables chaining. Bit 12 is the output enable.
- R6: Address 0x00 (no operation) and any address not listed in these requirements leave every register unchanged.
- R7: Address 0x02 requests readback. Payload bits 1..0 select the register: 00 returns the code, 01 returns the control word with its bits in the positions of R5, and other values return zero. During the next frame, the serial output presents eight zero bits and then the 16-bit value, MSB first. Each bit is valid before the bit-clock rise that shifts it out.
- R8: Address 0x56 with payload bit 0 set clears the code, control and readback state. With payload bit 0 clear, it does nothing.
- R9: While clear is high, the code output is zero at once. The stored code still accepts writes, and that stored code reappears when clear falls.
- R10: With chaining enabled and no readback pending, the serial output presents the bit that entered 24 bit-clock rises earlier. With chaining disabled and no readback pending, the serial output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial link |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sclk | input | 1 | Serial bit clock, synchronous to clk |
| sdin | input | 1 | Serial data input |
| latch | input | 1 | Frame commit strobe, acts on its rising level change |
| clear | input | 1 | Asynchronous clear, forces the code output to zero |
| sdo | output | 1 | Serial output for readback and chaining |
| dac_code | output | DATA_W | Converter code |
| out_en | output | 1 | Analog output enable |
| range_sel | output | 2 | Current range select |

## Verification
A register write appears on the outputs one clock after the first clock edge that sees the commit strobe high. The bench raises the strobe on a falling clock edge and checks on the next falling edge. A bit-clock rise moves the shift register one clock later, so the serial output is read on the falling edge just before each new bit-clock rise. That collects the readback or chained word in frame order. Clear acts without a clock, so its result is checked one nanosecond after clear changes, with no clock edge in between.

// File: rtl/dsf_pkg.sv
// Package dsf_pkg
// Shared command codes, control-field positions and types for the serial
// DAC front end. Field positions are fixed because the host encodes them.
package dsf_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] CMD_NOP   = 8'h00;
    localparam logic [ADDR_W-1:0] CMD_CODE  = 8'h01;
    localparam logic [ADDR_W-1:0] CMD_READ  = 8'h02;
    localparam logic [ADDR_W-1:0] CMD_CTRL  = 8'h55;
    localparam logic [ADDR_W-1:0] CMD_RESET = 8'h56;

    localparam int CTRL_RANGE_LSB = 0;
    localparam int CTRL_CHAIN_BIT = 3;
    localparam int CTRL_OEN_BIT   = 12;
    localparam int RESET_KEY_BIT  = 0;

    localparam logic [1:0] SEL_CODE = 2'b00;
    localparam logic [1:0] SEL_CTRL = 2'b01;

    typedef enum logic [1:0] {
        RNG_4_20 = 2'b00,
        RNG_0_20 = 2'b01,
        RNG_0_24 = 2'b10,
        RNG_RSVD = 2'b11
    } range_e;

    typedef struct packed {
        logic   out_en;
        logic   chain;
        range_e range;
    } ctrl_t;
endpackage

// File: rtl/dsf_shifter.sv
// Module dsf_shifter
// Oversamples the serial link on clk. A rising sclk shifts sdin into the
// frame register, and a rising latch raises a one-cycle commit pulse.
// A readback load replaces the frame register and wins over a shift in the
// same cycle. sdo shows the frame MSB when the caller enables it.
// Assumes sclk, sdin and latch are synchronous to clk and that each level
// lasts at least one clk period.
module dsf_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdin,
    input  logic               latch,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               sdo_drive,
    output logic [FRAME_W-1:0] frame,
    output logic               commit,
    output logic               sdo
);
    logic               sclk_q;
    logic               latch_q;
    logic [FRAME_W-1:0] shift_q;
    logic               sclk_rise;

    // Edge detection on the sampled link signals.
    assign sclk_rise = sclk & ~sclk_q;
    assign commit    = latch & ~latch_q;

    // Edge history and frame register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            shift_q <= '0;
        end else begin
            sclk_q  <= sclk;
            latch_q <= latch;
            if (load)
                shift_q <= load_val;
            else if (sclk_rise)
                shift_q <= {shift_q[FRAME_W-2:0], sdin};
        end
    end

    assign frame = shift_q;
    assign sdo   = sdo_drive & shift_q[FRAME_W-1];

    // R2: a bit-clock rise moves the frame one place and takes sdin.
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !load) |=> (shift_q == {$past(shift_q[FRAME_W-2:0]), $past(sdin)}));

    // R3: with no bit-clock rise and no load, the frame holds.
    p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !load) |=> $stable(shift_q));

    // R7: a readback load places the requested word in the frame.
    p_rb_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shift_q == $past(load_val)));
endmodule

// File: rtl/dsf_regfile.sv
// Module dsf_regfile
// Decodes a committed frame and holds the code and control registers and
// the readback-pending flag. It builds the readback word that the shifter
// loads. Assumes commit is a single-cycle pulse.
module dsf_regfile
    import dsf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [ADDR_W+DATA_W-1:0] frame,
    output logic [DATA_W-1:0]        code_q,
    output ctrl_t                    ctrl_q,
    output logic                     rb_pending,
    output logic                     load,
    output logic [ADDR_W+DATA_W-1:0] load_val
);
    localparam int FRAME_W = ADDR_W + DATA_W;

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] payload;
    logic [DATA_W-1:0] rb_word;
    logic              is_writer;

    // Split the frame into command and payload.
    assign addr    = frame[FRAME_W-1 -: ADDR_W];
    assign payload = frame[DATA_W-1:0];

    // Place the control fields at their host-visible bit positions.
    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_RANGE_LSB +: 2] = c.range;
        w[CTRL_CHAIN_BIT]      = c.chain;
        w[CTRL_OEN_BIT]        = c.out_en;
        return w;
    endfunction

    // Pick the register that a readback returns.
    always_comb begin
        case (payload[1:0])
            SEL_CODE: rb_word = code_q;
            SEL_CTRL: rb_word = ctrl_word(ctrl_q);
            default:  rb_word = '0;
        endcase
    end

    assign load      = commit && (addr == CMD_READ);
    assign load_val  = {{ADDR_W{1'b0}}, rb_word};
    assign is_writer = (addr == CMD_CODE) || (addr == CMD_CTRL) || (addr == CMD_RESET);

    // Act on a committed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= '0;
            ctrl_q     <= '0;
            rb_pending <= 1'b0;
        end else if (commit) begin
            rb_pending <= (addr == CMD_READ);
            case (addr)
                CMD_CODE: code_q <= payload;
                CMD_CTRL: begin
                    ctrl_q.range  <= range_e'(payload[CTRL_RANGE_LSB +: 2]);
                    ctrl_q.chain  <= payload[CTRL_CHAIN_BIT];
                    ctrl_q.out_en <= payload[CTRL_OEN_BIT];
                end
                CMD_RESET: begin
                    if (payload[RESET_KEY_BIT]) begin
                        code_q <= '0;
                        ctrl_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: without a commit, no register changes.
    p_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(code_q) && $stable(ctrl_q)));

    // R4: a code write stores the payload.
    p_code_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == CMD_CODE) |=> (code_q == $past(payload)));

    // R5: a control write takes the enable bit from its position.
    p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == CMD_CTRL) |=> (ctrl_q.out_en == $past(payload[CTRL_OEN_BIT])));

    // R6: no-op, readback and unknown commands leave the registers alone.
    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !is_writer) |=> ($stable(code_q) && $stable(ctrl_q)));

    // R8: a keyed reset returns every register to zero.
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == CMD_RESET && payload[RESET_KEY_BIT])
        |=> (code_q == '0 && ctrl_q == '0 && !rb_pending));
endmodule

// File: rtl/dac_serial_front.sv
// Module dac_serial_front
// Top of the serial front end. It joins the link shifter and the register
// file. It drives the code (gated to zero by clear), the output enable and
// the range select. sdo is live while a readback is pending or chaining is
// on. Assumes the serial link is synchronous to clk.
module dac_serial_front
    import dsf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              latch,
    input  logic              clear,
    output logic              sdo,
    output logic [DATA_W-1:0] dac_code,
    output logic              out_en,
    output logic [1:0]        range_sel
);
    localparam int FRAME_W = ADDR_W + DATA_W;

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] load_val;
    logic [DATA_W-1:0]  code_q;
    logic               commit;
    logic               load;
    logic               rb_pending;
    logic               sdo_drive;
    ctrl_t              ctrl_q;

    dsf_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sdin      (sdin),
        .latch     (latch),
        .load      (load),
        .load_val  (load_val),
        .sdo_drive (sdo_drive),
        .frame     (frame),
        .commit    (commit),
        .sdo       (sdo)
    );

    dsf_regfile #(.DATA_W(DATA_W)) u_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .frame      (frame),
        .code_q     (code_q),
        .ctrl_q     (ctrl_q),
        .rb_pending (rb_pending),
        .load       (load),
        .load_val   (load_val)
    );

    // Serial output is live for readback or for chaining.
    assign sdo_drive = rb_pending | ctrl_q.chain;

    // Clear gates the code without a clock and keeps the stored value.
    assign dac_code  = clear ? '0 : code_q;
    assign out_en    = ctrl_q.out_en;
    assign range_sel = ctrl_q.range;
endmodule

// File: tb/dac_serial_front_bench.sv
`timescale 1ns/1ps
module dac_serial_front_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdin = 1'b0, latch = 1'b0, clear = 1'b0;
    logic sdo, out_en;
    logic [15:0] dac_code;
    logic [1:0]  range_sel;
    logic [23:0] cap = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Scoreboard queues: requirement, kind of observation, expected value.
    string       rq[$];
    int          kq[$];
    logic [23:0] vq[$];
    event        mon_ev;

    always #2.5 clk = ~clk;

    dac_serial_front u_dac_serial_front (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .latch(latch),
        .clear(clear), .sdo(sdo), .dac_code(dac_code), .out_en(out_en),
        .range_sel(range_sel)
    );

    // Driver side: queue an expected observation and wake the monitor.
    task automatic expect_obs(input string req, input int kind, input logic [23:0] v);
        rq.push_back(req);
        kq.push_back(kind);
        vq.push_back(v);
        -> mon_ev;
    endtask

    // Monitor: pop the queued items and compare them with the ports now.
    initial begin
        forever begin
            @(mon_ev);
            while (rq.size() > 0) begin
                string       r;
                int          k;
                logic [23:0] e;
                logic [23:0] a;
                r = rq.pop_front();
                k = kq.pop_front();
                e = vq.pop_front();
                case (k)
                    0:       a = {8'h00, dac_code};
                    1:       a = {23'h0, out_en};
                    2:       a = {22'h0, range_sel};
                    3:       a = {23'h0, sdo};
                    default: a = cap;
                endcase
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s kind %0d: actual %h expected %h", r, k, a, e);
                end
            end
        end
    end

    // Shift n bits MSB first and record sdo just before each bit-clock rise.
    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            cap  = {cap[22:0], sdo};
            sdin = v[i];
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [15:0] p);
        send_bits(24, {8'h00, a, p});
    endtask

    // Raise the strobe for one clock; registers are updated on return.
    task automatic pulse_latch();
        @(negedge clk);
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_obs("R1", 0, 24'h0);
        expect_obs("R1", 1, 24'h0);
        expect_obs("R1", 2, 24'h0);
        expect_obs("R1", 3, 24'h0);

        send_frame(8'h01, 16'h1234);
        expect_obs("R3", 0, 24'h0);
        pulse_latch();
        expect_obs("R4", 0, 24'h1234);

        send_bits(28, {4'hF, 8'h01, 16'hABCD});
        pulse_latch();
        expect_obs("R2", 0, 24'hABCD);

        // Strobe held high: shifting goes on, no second commit.
        @(negedge clk);
        latch = 1'b1;
        @(negedge clk);
        send_frame(8'h01, 16'h5555);
        expect_obs("R3", 0, 24'hABCD);
        @(negedge clk);
        latch = 1'b0;
        @(negedge clk);
        pulse_latch();
        expect_obs("R3", 0, 24'h5555);

        send_frame(8'h55, 16'h1009);
        pulse_latch();
        expect_obs("R5", 1, 24'h1);
        expect_obs("R5", 2, 24'h1);
        send_frame(8'h55, 16'h0002);
        pulse_latch();
        expect_obs("R5", 1, 24'h0);
        expect_obs("R5", 2, 24'h2);

        send_frame(8'h00, 16'hFFFF);
        pulse_latch();
        expect_obs("R6", 0, 24'h5555);
        expect_obs("R6", 2, 24'h2);
        send_frame(8'h7F, 16'h0000);
        pulse_latch();
        expect_obs("R6", 0, 24'h5555);
        expect_obs("R6", 1, 24'h0);
        expect_obs("R6", 2, 24'h2);

        send_frame(8'h02, 16'h0000);
        pulse_latch();
        send_frame(8'h00, 16'h0000);
        expect_obs("R7", 4, 24'h005555);
        pulse_latch();
        send_frame(8'h02, 16'h0001);
        pulse_latch();
        send_frame(8'h00, 16'h0000);
        expect_obs("R7", 4, 24'h000002);
        pulse_latch();
        send_frame(8'h02, 16'h0003);
        pulse_latch();
        send_frame(8'h00, 16'h0000);
        expect_obs("R7", 4, 24'h000000);
        pulse_latch();

        send_frame(8'h55, 16'h0008);
        pulse_latch();
        send_frame(8'hA5, 16'hC3E1);
        send_frame(8'h00, 16'h0000);
        expect_obs("R10", 4, 24'hA5C3E1);
        send_frame(8'h55, 16'h0000);
        pulse_latch();
        send_frame(8'hFF, 16'hFFFF);
        expect_obs("R10", 4, 24'h000000);
        expect_obs("R10", 3, 24'h0);

        @(negedge clk);
        clear = 1'b1;
        #1;
        expect_obs("R9", 0, 24'h0);
        send_frame(8'h01, 16'h0777);
        pulse_latch();
        expect_obs("R9", 0, 24'h0);
        @(negedge clk);
        clear = 1'b0;
        #1;
        expect_obs("R9", 0, 24'h0777);

        send_frame(8'h55, 16'h1001);
        pulse_latch();
        send_frame(8'h56, 16'h0000);
        pulse_latch();
        expect_obs("R8", 0, 24'h0777);
        expect_obs("R8", 1, 24'h1);
        send_frame(8'h56, 16'h0001);
        pulse_latch();
        expect_obs("R8", 0, 24'h0);
        expect_obs("R8", 1, 24'h0);
        expect_obs("R8", 2, 24'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule